// File: doc/BRIEF.md
# Telemetry Frame Word Translator

This block sits in a byte stream that has already been aligned to telemetry frames. Every frame has the same fixed layout: four sync bytes, one line-number byte, and a fixed number of intensity samples, each one byte wide. The block keeps track of where each byte falls in the frame. Sync and line-number bytes pass through unchanged. Each intensity sample is translated: its bit order is reversed and a fixed set of bits is then inverted. Every output byte carries a tag for its kind, plus markers for the start of a frame, the end of a frame and the end of a picture.

The block does not search for sync. The upstream aligner tells it where a frame begins through a start flag that travels with a byte. Both sides of the block use valid/ready handshakes. One register stage sits between input and output, and a stalled output holds the input back, so no byte is ever lost.

Top module: `tlm_frame_xlate`

## Requirements
- R1: While reset is held and right after it, out_valid is 0 and in_ready is 1. The first accepted byte is frame position 0 (first sync byte) of picture frame 0.
- R2: A data byte b leaves as reverse(b) XOR MASK. Here reverse maps bit i to bit 7-i, and MASK defaults to 8'h2A (bits 1, 3 and 5 set, bit 0 being the LSB). Example: 8'h01 gives 8'hAA.
- R3: Sync and line-number bytes leave with their value unchanged.
- R4: out_tag is 2'b00 for frame positions 0 to 3 (sync), 2'b01 for position 4 (line number), and 2'b10 for positions 5 to 4+DATA_BYTES (data). The value 2'b11 never appears on a valid output.
- R5: Positions advance by one per accepted byte. After position 4+DATA_BYTES the next byte is position 0 again. out_sof is 1 exactly on position-0 bytes, and out_eof is 1 exactly on the last data byte.
- R6: An accepted byte that has in_sof=1 is treated as position 0, whatever the counter held. Counting continues from there, and the frame number does not change. in_sof has no effect on a byte that is not accepted.
- R7: Frames are numbered from 0 after reset and advance only on a completed frame (out_eof), wrapping after FRAMES_PER_PIC frames. out_eop is 1 together with out_eof on the last frame of each picture, and 0 otherwise.
- R8: A byte accepted at a clock edge appears on the outputs right after that edge. in_ready equals (not out_valid) or out_ready.
- R9: While out_valid=1 and out_ready=0, every output stays stable and in_ready is 0. Bytes leave in the order they were accepted, none dropped and none repeated.
- R10: XFORM_ORDER=0 (invert after reversal) and XFORM_ORDER=1 (invert with a mirrored mask before reversal) produce identical output for every byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Block can take the input byte |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Marks this byte as the first sync byte of a frame |
| out_valid | output | 1 | Output byte is present |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | Output byte, translated if it is a data byte |
| out_tag | output | 2 | Byte kind: 00 sync, 01 line number, 10 data |
| out_sof | output | 1 | First sync byte of a frame |
| out_eof | output | 1 | Last data byte of a frame |
| out_eop | output | 1 | Last data byte of the last frame of a picture |

## Verification
The risky overlap is a frame-start flag that arrives on the very byte the counter holds as the last data sample. In that cycle the restart and the end-of-frame wrap both want to set the next position and the frame number. The bench drives the stream until its own model reaches the last data position and then raises in_sof on that byte. It expects the byte to come out tagged as sync with out_sof set, with no end-of-frame or end-of-picture marker, and with the picture frame count unchanged in the bytes that follow. Random frame starts also land on this position under random backpressure, and a reference model checks each of these outputs.

// File: rtl/tlm_xlate_pkg.sv
package tlm_xlate_pkg;

    typedef enum logic [1:0] {
        TAG_SYNC = 2'b00,
        TAG_LINE = 2'b01,
        TAG_DATA = 2'b10
    } byte_tag_e;

    localparam int SYNC_BYTES = 4;
    localparam int HDR_BYTES  = SYNC_BYTES + 1;

    typedef struct packed {
        logic [7:0] data;
        byte_tag_e  tag;
        logic       sof;
        logic       eof;
        logic       eop;
    } out_word_t;

endpackage

// File: rtl/tlm_byte_xform.sv
module tlm_byte_xform #(
    parameter int         W           = 8,
    parameter logic [7:0] MASK        = 8'h2A,
    parameter int         XFORM_ORDER = 0
) (
    input  logic [W-1:0] in_byte,
    output logic [W-1:0] out_byte
);

    logic [W-1:0] mask_w;
    logic [W-1:0] mask_mirror;
    logic [W-1:0] rev_in;
    logic [W-1:0] pre_inv;
    logic [W-1:0] rev_pre;
    logic [W-1:0] path_after;
    logic [W-1:0] path_before;

    assign mask_w = W'(MASK);

    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign rev_in[i]      = in_byte[W-1-i];
        assign mask_mirror[i] = mask_w[W-1-i];
        assign rev_pre[i]     = pre_inv[W-1-i];
    end

    assign pre_inv     = in_byte ^ mask_mirror;
    assign path_after  = rev_in ^ mask_w;
    assign path_before = rev_pre;

    if (XFORM_ORDER == 0) begin : g_inv_after
        assign out_byte = path_after;
    end else begin : g_inv_before
        assign out_byte = path_before;
    end

    // R10
    always_comb begin
        if (!$isunknown(in_byte)) begin
            order_equiv_chk: assert (path_after == path_before);
        end
    end

endmodule

// File: rtl/tlm_pos_tracker.sv
module tlm_pos_tracker
    import tlm_xlate_pkg::*;
#(
    parameter int DATA_BYTES     = 240,
    parameter int FRAMES_PER_PIC = 256
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    input  logic      restart,
    output byte_tag_e tag,
    output logic      first,
    output logic      last_data,
    output logic      last_frame
);

    localparam int FRAME_LEN = HDR_BYTES + DATA_BYTES;
    localparam int POS_W     = $clog2(FRAME_LEN + 1);
    localparam int FR_W      = (FRAMES_PER_PIC > 1) ? $clog2(FRAMES_PER_PIC) : 1;
    localparam logic [POS_W-1:0] POS_LAST  = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0] POS_LINE  = POS_W'(SYNC_BYTES);
    localparam logic [FR_W-1:0]  FR_LAST   = FR_W'(FRAMES_PER_PIC - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [FR_W-1:0]  frame;
    } trk_state_t;

    trk_state_t       st_d, st_q;
    logic [POS_W-1:0] eff_pos;

    always_comb begin
        st_d    = st_q;
        eff_pos = restart ? '0 : st_q.pos;

        if (eff_pos < POS_LINE) begin
            tag = TAG_SYNC;
        end else if (eff_pos == POS_LINE) begin
            tag = TAG_LINE;
        end else begin
            tag = TAG_DATA;
        end
        first      = (eff_pos == '0);
        last_data  = (eff_pos == POS_LAST);
        last_frame = (st_q.frame == FR_LAST);

        if (adv) begin
            if (eff_pos == POS_LAST) begin
                st_d.pos   = '0;
                st_d.frame = (st_q.frame == FR_LAST) ? '0 : st_q.frame + 1'b1;
            end else begin
                st_d.pos   = eff_pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pos <= POS_LAST);

    // R7
    frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.frame <= FR_LAST);

    // R6
    restart_hold_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && restart && POS_LAST != '0) |=> (st_q.pos == 1 && $stable(st_q.frame)));

endmodule

// File: rtl/tlm_out_stage.sv
module tlm_out_stage
    import tlm_xlate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  out_word_t load_word,
    input  logic      take,
    output logic      can_load,
    output logic      hold_valid,
    output out_word_t hold_word
);

    typedef struct packed {
        logic      valid;
        out_word_t word;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        can_load = !st_q.valid || take;
        if (load) begin
            st_d.valid = 1'b1;
            st_d.word  = load_word;
        end else if (take) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_valid = st_q.valid;
    assign hold_word  = st_q.word;

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && !take) |=> (st_q.valid && $stable(st_q.word)));

    // R8
    load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.valid && st_q.word == $past(load_word)));

endmodule

// File: rtl/tlm_frame_xlate.sv
module tlm_frame_xlate
    import tlm_xlate_pkg::*;
#(
    parameter int         DATA_BYTES     = 240,
    parameter int         FRAMES_PER_PIC = 256,
    parameter logic [7:0] MASK           = 8'h2A,
    parameter int         XFORM_ORDER    = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic [1:0] out_tag,
    output logic       out_sof,
    output logic       out_eof,
    output logic       out_eop
);

    logic       in_fire;
    byte_tag_e  cur_tag;
    logic       cur_first;
    logic       cur_last;
    logic       cur_last_frame;
    logic [7:0] xf_byte;
    out_word_t  word_d;
    out_word_t  word_q;
    logic       can_load;

    assign in_fire = in_valid && in_ready;

    tlm_pos_tracker #(
        .DATA_BYTES     (DATA_BYTES),
        .FRAMES_PER_PIC (FRAMES_PER_PIC)
    ) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (in_fire),
        .restart    (in_sof),
        .tag        (cur_tag),
        .first      (cur_first),
        .last_data  (cur_last),
        .last_frame (cur_last_frame)
    );

    tlm_byte_xform #(
        .W           (8),
        .MASK        (MASK),
        .XFORM_ORDER (XFORM_ORDER)
    ) u_xf (
        .in_byte  (in_data),
        .out_byte (xf_byte)
    );

    always_comb begin
        word_d      = '0;
        word_d.tag  = cur_tag;
        word_d.data = (cur_tag == TAG_DATA) ? xf_byte : in_data;
        word_d.sof  = cur_first;
        word_d.eof  = cur_last;
        word_d.eop  = cur_last && cur_last_frame;
    end

    tlm_out_stage u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (in_fire),
        .load_word  (word_d),
        .take       (out_ready),
        .can_load   (can_load),
        .hold_valid (out_valid),
        .hold_word  (word_q)
    );

    assign in_ready = can_load;
    assign out_data = word_q.data;
    assign out_tag  = word_q.tag;
    assign out_sof  = word_q.sof;
    assign out_eof  = word_q.eof;
    assign out_eop  = word_q.eop;

    // R4
    tag_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_tag != 2'b11));

    // R5
    sof_is_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sof) |-> (out_tag == TAG_SYNC && !out_eof));

    // R5
    eof_is_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eof) |-> (out_tag == TAG_DATA));

    // R7
    eop_with_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eop) |-> out_eof);

    // R9
    ready_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/tb_tlm_frame_xlate.sv
module tb_tlm_frame_xlate;

    localparam int N     = 6;
    localparam int F     = 3;
    localparam int LAST  = 4 + N;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_sof = 1'b0;
    logic       out_ready = 1'b0;
    logic       in_ready, out_valid, out_sof, out_eof, out_eop;
    logic [7:0] out_data;
    logic [1:0] out_tag;
    logic       in_ready_b, out_valid_b, out_sof_b, out_eof_b, out_eop_b;
    logic [7:0] out_data_b;
    logic [1:0] out_tag_b;

    always #2 clk = ~clk;

    tlm_frame_xlate #(.DATA_BYTES(N), .FRAMES_PER_PIC(F), .XFORM_ORDER(0)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sof(in_sof), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_tag(out_tag), .out_sof(out_sof), .out_eof(out_eof),
        .out_eop(out_eop));

    tlm_frame_xlate #(.DATA_BYTES(N), .FRAMES_PER_PIC(F), .XFORM_ORDER(1)) dut_alt (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_b),
        .in_data(in_data), .in_sof(in_sof), .out_valid(out_valid_b), .out_ready(out_ready),
        .out_data(out_data_b), .out_tag(out_tag_b), .out_sof(out_sof_b), .out_eof(out_eof_b),
        .out_eop(out_eop_b));

    int n_chk = 0;
    int n_fail = 0;
    int m_pos = 0;
    int m_frame = 0;
    int n_in = 0;
    int n_out = 0;
    logic [12:0] expq[$];
    logic        prev_stall = 1'b0;
    logic [12:0] prev_word = '0;
    logic        done = 1'b0;

    function automatic logic [7:0] ref_xf(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r ^ 8'h2A;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    function automatic logic [12:0] model_push(input logic [7:0] b, input logic s);
        logic [1:0] t;
        logic [7:0] d;
        logic fs, fe, fp;
        if (s) m_pos = 0;
        t  = (m_pos < 4) ? 2'b00 : (m_pos == 4) ? 2'b01 : 2'b10;
        d  = (t == 2'b10) ? ref_xf(b) : b;
        fs = (m_pos == 0);
        fe = (m_pos == LAST);
        fp = fe && (m_frame == F - 1);
        if (fe) begin
            m_pos = 0;
            m_frame = (m_frame + 1) % F;
        end else begin
            m_pos++;
        end
        return {d, t, fs, fe, fp};
    endfunction

    task automatic step(input logic v, input logic [7:0] d, input logic s, input logic r);
        logic fo, fi;
        logic [12:0] e, a;
        @(negedge clk);
        in_valid = v; in_data = d; in_sof = s; out_ready = r;
        #1;
        a = {out_data, out_tag, out_sof, out_eof, out_eop};
        // R8: ready rule
        chk(in_ready == (!out_valid || out_ready), "R8 in_ready", in_ready, !out_valid || out_ready);
        if (prev_stall) begin
            // R9: stalled output must hold
            chk(out_valid && a == prev_word, "R9 stall hold", a, prev_word);
        end
        prev_stall = out_valid && !out_ready;
        prev_word  = a;
        fo = out_valid && out_ready;
        fi = in_valid && in_ready;
        if (fo) begin
            n_out++;
            if (expq.size() == 0) begin
                chk(1'b0, "R9 extra output", a, 0);
            end else begin
                e = expq.pop_front();
                if (e[4:3] == 2'b10) chk(a[12:5] == e[12:5], "R2 data xform", a[12:5], e[12:5]);
                else                 chk(a[12:5] == e[12:5], "R3 pass-through", a[12:5], e[12:5]);
                chk(a[4:3] == e[4:3], "R4 tag", a[4:3], e[4:3]);
                chk(a[2:1] == e[2:1], "R5 R6 sof/eof", a[2:1], e[2:1]);
                chk(a[0] == e[0], "R7 eop", a[0], e[0]);
                chk(out_data_b == out_data, "R10 order variant", out_data_b, out_data);
            end
        end
        if (fi) begin
            n_in++;
            expq.push_back(model_push(d, s));
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [12:0] e;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 after reset", {out_valid, in_ready}, 2'b01);

        // Directed: three full frames, corner data bytes, no sof (R1 counter start)
        for (int k = 0; k < 3 * (LAST + 1); k++) begin
            logic [7:0] b;
            b = (k % 3 == 0) ? 8'h00 : (k % 3 == 1) ? 8'h01 : 8'hFF;
            step(1'b1, b, 1'b0, 1'b1);
        end
        // R2 explicit reference values
        chk(ref_xf(8'h01) == 8'hAA, "R2 ref 01", ref_xf(8'h01), 8'hAA);
        chk(ref_xf(8'hFF) == 8'hD5, "R2 ref FF", ref_xf(8'hFF), 8'hD5);

        // Directed stall: R9
        step(1'b1, 8'h5C, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 8'hA3, 1'b0, 1'b0);
            chk(in_ready == 1'b0, "R9 input blocked", in_ready, 0);
        end
        step(1'b0, 8'h00, 1'b0, 1'b1);

        // Directed: sof on the last data position (R6 vs R5 collision)
        while (m_pos != LAST) step(1'b1, 8'h3C, 1'b0, 1'b1);
        begin
            int fr_before;
            fr_before = m_frame;
            step(1'b1, 8'h77, 1'b1, 1'b1);
            e = expq[expq.size() - 1];
            chk(e[4:3] == 2'b00 && e[2] && !e[1], "R6 restart model", e[4:0], 5'b00100);
            chk(m_frame == fr_before, "R6 frame kept", m_frame, fr_before);
        end
        // R6: sof with invalid byte is ignored
        step(1'b0, 8'h00, 1'b1, 1'b1);
        for (int k = 0; k < LAST + 2; k++) step(1'b1, 8'(k * 37), 1'b0, 1'b1);

        // Random phase with fixed seed
        void'($urandom(32'h1234_5678));
        for (int k = 0; k < 6000; k++) begin
            step(($urandom % 10) < 7, 8'($urandom), ($urandom % 50) == 0, ($urandom % 10) < 6);
        end

        // Drain
        for (int k = 0; k < 8; k++) step(1'b0, 8'h00, 1'b0, 1'b1);
        chk(expq.size() == 0 && out_valid == 1'b0, "R9 all drained", expq.size(), 0);
        chk(n_in == n_out, "R9 count in/out", n_out, n_in);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule